// File: doc/BRIEF.md
# Edge-Sensed External Interrupt Controller

This block turns five external interrupt request lines into software-visible request flags and one combined interrupt output. Every line is brought into the clock domain through a two-stage synchronizer. An edge detector then looks for a transition, and a per-line select bit decides whether a rising or a falling transition counts. A qualifying transition sets a sticky flag. Each flag is gated by its own enable bit, and the gated flags are ORed into a level interrupt output.

A separate converter-trigger input goes through the same synchronizer and edge detector. Its polarity comes from the select bit of line 4. It produces a single-cycle trigger pulse and has no flag.

Software uses a small 8-bit register bus: an address, a write strobe, write data and combinational read data. A flag can only be removed by writing 0 to its bit. Each flag is held by a two-state machine with the states FLAG_IDLE and FLAG_PEND. The transition SET (FLAG_IDLE to FLAG_PEND) fires on a qualified edge. The transition CLEAR (FLAG_PEND to FLAG_IDLE) fires on a zero-write when no edge arrives in the same cycle. In every other case the state holds (HOLD).

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the select register (address 0) reads 0xE0, and every enable and flag register reads 0x00.
- R2: Select bits 4:0 are writable and read back. Bits 7:5 of address 0 always read 1 and ignore writes.
- R3: A select bit of 0 sets a line's flag on a falling transition. A select bit of 1 sets it on a rising transition. The opposite transition leaves the flag at 0.
- R4: A line that changes between two clock edges has its flag readable as 1 from the fourth following rising edge, and not before.
- R5: Writing 0 to a flag bit clears it. Writing 1 to a flag bit leaves it unchanged, and bits written 1 in the same write keep their value.
- R6: When a qualified edge and a zero-write to the same flag fall in the same cycle, the flag ends set.
- R7: The output irq_out is high exactly while some flag and its enable are both 1. It stays high until software clears the flag.
- R8: Rewriting select bits while the lines are stable never sets a flag.
- R9: The trigger output gives exactly one one-cycle pulse per transition of trig_in in the direction chosen by select bit 4. It never sets a flag.
- R10: The register map is as follows. Address 0 is select. Address 1 holds enables for lines 0-3 in bits 3:0. Address 2 holds the enable for line 4 in bit 0. Address 3 holds flags for lines 0-3 in bits 3:0. Address 4 holds the flag for line 4 in bit 0. Unimplemented bits, and addresses 5-7, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_pin | input | 5 | Asynchronous interrupt request lines 0-4 |
| trig_in | input | 1 | Asynchronous converter-trigger line |
| irq_out | output | 1 | Combined enabled interrupt request, level |
| trig_pulse | output | 1 | One-cycle converter-trigger pulse |

## Verification
The checker assumes that the select bit of line 4 is not changed in the same few cycles as a transition of trig_in. A reversed polarity could otherwise qualify a rise and then a fall back-to-back, giving two adjacent pulses. The checker also assumes that request lines are held for several cycles between transitions. The stimulus writes the select register only while all lines are quiet. It then waits at least six cycles after every line change before it reads back or writes again. The one collision case is the exception: there the clear write is deliberately placed in the cycle in which the registered edge is present.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam int ADR_ESEL   = 0;
    localparam int ADR_EN_LO  = 1;
    localparam int ADR_EN_HI  = 2;
    localparam int ADR_FLG_LO = 3;
    localparam int ADR_FLG_HI = 4;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_t;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic rise_sel,
    output logic edge_pulse
);
    logic meta_q;
    logic sync_q;
    logic prev_q;
    logic rose;
    logic fell;

    // polarity applied only at qualification so a select change cannot fake an edge
    always_comb begin
        rose = sync_q & ~prev_q;
        fell = ~sync_q & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q     <= 1'b0;
            sync_q     <= 1'b0;
            prev_q     <= 1'b0;
            edge_pulse <= 1'b0;
        end else begin
            meta_q     <= pin_async;
            sync_q     <= meta_q;
            prev_q     <= sync_q;
            edge_pulse <= rise_sel ? rose : fell;
        end
    end
endmodule

// File: rtl/irq_flag_fsm.sv
module irq_flag_fsm
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_in,
    input  logic clr_req,
    output logic flag
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (edge_in)               state_d = FLAG_PEND; // SET
            FLAG_PEND: if (clr_req && !edge_in)   state_d = FLAG_IDLE; // CLEAR, edge wins
            default:                              state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FLAG_PEND: flag = 1'b1;
            default:   flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int NUM_PINS = 5,
    parameter int LO_PINS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] irq_pin,
    input  logic              trig_in,
    output logic              irq_out,
    output logic              trig_pulse
);
    localparam int HI_PINS  = NUM_PINS - LO_PINS;
    localparam int TRIG_SEL = NUM_PINS - 1;

    logic [NUM_PINS-1:0] esel_q;
    logic [NUM_PINS-1:0] en_q;
    logic [NUM_PINS-1:0] edge_q;
    logic [NUM_PINS-1:0] flag_q;
    logic [NUM_PINS-1:0] clr_vec;
    logic                wr_esel;
    logic                wr_en_lo;
    logic                wr_en_hi;
    logic                wr_flg_lo;
    logic                wr_flg_hi;
    logic                unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_PINS];

    always_comb begin
        wr_esel   = bus_wr && (bus_addr == ADDR_W'(ADR_ESEL));
        wr_en_lo  = bus_wr && (bus_addr == ADDR_W'(ADR_EN_LO));
        wr_en_hi  = bus_wr && (bus_addr == ADDR_W'(ADR_EN_HI));
        wr_flg_lo = bus_wr && (bus_addr == ADDR_W'(ADR_FLG_LO));
        wr_flg_hi = bus_wr && (bus_addr == ADDR_W'(ADR_FLG_HI));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            esel_q <= '0;
            en_q   <= '0;
        end else begin
            if (wr_esel)  esel_q <= bus_wdata[NUM_PINS-1:0];
            if (wr_en_lo) en_q[LO_PINS-1:0] <= bus_wdata[LO_PINS-1:0];
            if (wr_en_hi) en_q[NUM_PINS-1:LO_PINS] <= bus_wdata[HI_PINS-1:0];
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_line
        if (i < LO_PINS) begin : g_lo
            assign clr_vec[i] = wr_flg_lo && !bus_wdata[i];
        end else begin : g_hi
            assign clr_vec[i] = wr_flg_hi && !bus_wdata[i-LO_PINS];
        end

        irq_edge_det u_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_async  (irq_pin[i]),
            .rise_sel   (esel_q[i]),
            .edge_pulse (edge_q[i])
        );

        irq_flag_fsm u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .edge_in (edge_q[i]),
            .clr_req (clr_vec[i]),
            .flag    (flag_q[i])
        );
    end

    irq_edge_det u_trig_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async  (trig_in),
        .rise_sel   (esel_q[TRIG_SEL]),
        .edge_pulse (trig_pulse)
    );

    assign irq_out = |(flag_q & en_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(ADR_ESEL): begin
                bus_rdata                 = '1;
                bus_rdata[NUM_PINS-1:0]   = esel_q;
            end
            ADDR_W'(ADR_EN_LO):  bus_rdata[LO_PINS-1:0] = en_q[LO_PINS-1:0];
            ADDR_W'(ADR_EN_HI):  bus_rdata[HI_PINS-1:0] = en_q[NUM_PINS-1:LO_PINS];
            ADDR_W'(ADR_FLG_LO): bus_rdata[LO_PINS-1:0] = flag_q[LO_PINS-1:0];
            ADDR_W'(ADR_FLG_HI): bus_rdata[HI_PINS-1:0] = flag_q[NUM_PINS-1:LO_PINS];
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
    import ext_irq_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int NUM_PINS = 5,
    parameter int LO_PINS  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                irq_out,
    input logic                trig_pulse,
    input logic [NUM_PINS-1:0] flag,
    input logic [NUM_PINS-1:0] edge_p,
    input logic [NUM_PINS-1:0] en
);
    logic [NUM_PINS-1:0] zero_wr;
    logic                unused_chk_hi;

    assign unused_chk_hi = ^bus_wdata[DATA_W-1:LO_PINS];

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        if (i < LO_PINS) begin : g_lo
            assign zero_wr[i] = bus_wr && (bus_addr == ADDR_W'(ADR_FLG_LO)) && !bus_wdata[i];
        end else begin : g_hi
            assign zero_wr[i] = bus_wr && (bus_addr == ADDR_W'(ADR_FLG_HI)) && !bus_wdata[i-LO_PINS];
        end

        p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !zero_wr[i]) |=> flag[i]);

        p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            edge_p[i] |=> flag[i]);

        p_set_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> $past(edge_p[i]));
    end

    p_reserved_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADR_ESEL)) |-> (bus_rdata[DATA_W-1:NUM_PINS] == '1));

    p_irq_needs_enabled_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & en) == '0) |-> !irq_out);

    p_trig_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_PINS (NUM_PINS),
    .LO_PINS  (LO_PINS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_out    (irq_out),
    .trig_pulse (trig_pulse),
    .flag       (flag_q),
    .edge_p     (edge_q),
    .en         (en_q)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] irq_pin = '0;
    logic       trig_in = 1'b0;
    logic       irq_out;
    logic       trig_pulse;

    int checks = 0;
    int errors = 0;
    int trig_cnt = 0;
    bit trig_prev = 1'b0;
    bit trig_double = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ext_irq_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_pin    (irq_pin),
        .trig_in    (trig_in),
        .irq_out    (irq_out),
        .trig_pulse (trig_pulse)
    );

    always @(negedge clk) begin
        if (trig_pulse) trig_cnt++;
        if (trig_pulse && trig_prev) trig_double = 1'b1;
        trig_prev = trig_pulse;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic get_flags(output logic [4:0] f);
        logic [7:0] lo;
        logic [7:0] hi;
        bus_read(3'd3, lo);
        bus_read(3'd4, hi);
        f = {hi[0], lo[3:0]};
    endtask

    task automatic clear_all();
        bus_write(3'd3, 8'h00);
        bus_write(3'd4, 8'h00);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [4:0] fl;
        int base;

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset values
        bus_read(3'd0, rd); check(rd == 8'hE0, "R1 esel reset", rd, 8'hE0);
        for (int a = 1; a < 5; a++) begin
            bus_read(a[2:0], rd); check(rd == 8'h00, "R1 reg reset", rd, 0);
        end

        // R2: select writable, reserved bits stuck at 1
        bus_write(3'd0, 8'h15); bus_read(3'd0, rd); check(rd == 8'hF5, "R2 esel rw", rd, 8'hF5);
        bus_write(3'd0, 8'h0A); bus_read(3'd0, rd); check(rd == 8'hEA, "R2 esel rw", rd, 8'hEA);
        bus_write(3'd0, 8'h00);

        // R10: map, unimplemented bits and addresses
        bus_write(3'd1, 8'hFF); bus_read(3'd1, rd); check(rd == 8'h0F, "R10 en lo", rd, 8'h0F);
        bus_write(3'd2, 8'hFF); bus_read(3'd2, rd); check(rd == 8'h01, "R10 en hi", rd, 8'h01);
        for (int a = 5; a < 8; a++) begin
            bus_write(a[2:0], 8'hFF);
            bus_read(a[2:0], rd); check(rd == 8'h00, "R10 empty addr", rd, 0);
        end

        // R3/R7: sweep every line x polarity x direction, all enabled
        for (int p = 0; p < 5; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    irq_pin[p] = (dir == 0);
                    wait_cyc(6);
                    clear_all();
                    bus_write(3'd0, 8'(pol << p));
                    wait_cyc(2);
                    clear_all();
                    wait_cyc(1);
                    check(irq_out == 1'b0, "R7 idle irq", irq_out, 0);
                    irq_pin[p] = (dir == 1);
                    wait_cyc(6);
                    get_flags(fl);
                    base = (pol == dir) ? (1 << p) : 0;
                    check(fl == 5'(base), "R3 edge sweep", fl, base);
                    check(irq_out == (pol == dir), "R7 irq level", irq_out, (pol == dir));
                    irq_pin[p] = 1'b0;
                    wait_cyc(6);
                    clear_all();
                end
            end
        end

        // R7: enable gating, level holds until clear
        bus_write(3'd0, 8'h1F);
        bus_write(3'd1, 8'h00); bus_write(3'd2, 8'h00);
        irq_pin[4] = 1'b1; wait_cyc(6);
        get_flags(fl);
        check(fl == 5'h10, "R7 flag while disabled", fl, 5'h10);
        check(irq_out == 1'b0, "R7 disabled no irq", irq_out, 0);
        bus_write(3'd2, 8'h01); wait_cyc(1);
        check(irq_out == 1'b1, "R7 enable raises irq", irq_out, 1);
        wait_cyc(10);
        check(irq_out == 1'b1, "R7 level held", irq_out, 1);
        bus_write(3'd4, 8'h00); wait_cyc(1);
        check(irq_out == 1'b0, "R7 clear drops irq", irq_out, 0);
        irq_pin[4] = 1'b0; wait_cyc(6);

        // R5: 1-writes ignored, 0-write clears only its bit
        irq_pin[0] = 1'b1; irq_pin[1] = 1'b1; wait_cyc(6);
        bus_write(3'd3, 8'hFF);
        get_flags(fl); check(fl == 5'h03, "R5 write one ignored", fl, 5'h03);
        bus_write(3'd3, 8'hFE);
        get_flags(fl); check(fl == 5'h02, "R5 clear one bit", fl, 5'h02);
        irq_pin[0] = 1'b0; irq_pin[1] = 1'b0; wait_cyc(6);
        clear_all();

        // R8: rewriting the select while lines are stable
        irq_pin[2] = 1'b1; wait_cyc(6); clear_all();
        bus_write(3'd0, 8'h00); wait_cyc(6);
        bus_write(3'd0, 8'h1F); wait_cyc(6);
        bus_write(3'd0, 8'h00); wait_cyc(6);
        get_flags(fl); check(fl == 5'h00, "R8 no spurious flag", fl, 0);
        irq_pin[2] = 1'b0; wait_cyc(6); clear_all();

        // R4: latency (line 1 rising)
        bus_write(3'd0, 8'h1F);
        @(negedge clk); irq_pin[1] = 1'b1;
        wait_cyc(3); get_flags(fl); check(fl[1] == 1'b0, "R4 not before edge 4", fl[1], 0);
        wait_cyc(1); get_flags(fl); check(fl[1] == 1'b1, "R4 set at edge 4", fl[1], 1);

        // R6: clear collides with a fresh edge
        irq_pin[1] = 1'b0; wait_cyc(6);
        get_flags(fl); check(fl[1] == 1'b1, "R6 pre set", fl[1], 1);
        @(negedge clk); irq_pin[1] = 1'b1;
        wait_cyc(3);
        bus_addr = 3'd3; bus_wdata = 8'hFD; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        get_flags(fl); check(fl[1] == 1'b1, "R6 edge wins", fl[1], 1);
        bus_write(3'd3, 8'h00);
        get_flags(fl); check(fl[1] == 1'b0, "R6 later clear", fl[1], 0);
        irq_pin[1] = 1'b0; wait_cyc(6); clear_all();

        // R9: trigger pulses follow select bit 4, no flag
        bus_write(3'd0, 8'h10); wait_cyc(2);
        trig_cnt = 0;
        trig_in = 1'b1; wait_cyc(6);
        check(trig_cnt == 1, "R9 rise pulse", trig_cnt, 1);
        trig_in = 1'b0; wait_cyc(6);
        check(trig_cnt == 1, "R9 fall ignored", trig_cnt, 1);
        bus_write(3'd0, 8'h00); wait_cyc(2);
        trig_in = 1'b1; wait_cyc(6);
        check(trig_cnt == 1, "R9 rise ignored", trig_cnt, 1);
        trig_in = 1'b0; wait_cyc(6);
        check(trig_cnt == 2, "R9 fall pulse", trig_cnt, 2);
        get_flags(fl); check(fl == 5'h00, "R9 no flag", fl, 0);
        check(trig_double == 1'b0, "R9 single cycle", trig_double, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule